// File: doc/BRIEF.md
# Nested interrupt pending/active tracker

The block sits beside a processor core and keeps, for each of `NSRC` interrupt sources (up to 32), a pending flag and an active flag. It decides which source the core should take next and whether that source may preempt the handler that is running. Each source has its own configuration inputs. An enable bit decides whether the source can be taken. A mode bit selects level or pulse behaviour. A `PRIO_W`-bit priority value (3 to 8 bits) is split by a shared `sub_bits` setting: the upper bits form the preempting group and the low `sub_bits` bits form the sub-priority.

The core signals when a handler starts with the `entry` strobe. Entry accepts the source currently offered on `take_id`. The core signals when a handler ends with the `ret` strobe. Active handlers are kept on a nesting stack of source numbers, and the top entry sets the current execution priority. A two-state controller tracks whether the core is in thread mode (`S_THREAD`, nothing active) or inside a handler (`S_HANDLER`). `S_THREAD` moves to `S_HANDLER` on an accepted entry. `S_HANDLER` returns to `S_THREAD` on a return that pops the last stack entry. Any other entry or return stays in `S_HANDLER`.

A source that must wait is offered again once a return lowers the execution priority. This lets the core chain straight into the next handler.

Top module: `nvt_top`

## Requirements
- R1: After reset no source is pending or active and `take_req` is low.
- R2: A level-mode source (`pulse_mode` bit 0) becomes pending one clock after its input is high while it is not active. A high input while the source is active does not make it pending.
- R3: A pulse-mode source (`pulse_mode` bit 1) becomes pending one clock after a low-to-high change of its input. An input held high does not set it again. A `set_pend` bit makes its source pending in either mode.
- R4: With `take_req` high, an `entry` strobe makes source `take_id` active and clears its pending flag on the same clock edge.
- R5: On a return from a level-mode handler, the source becomes pending again if its input is still high. Otherwise it becomes inactive.
- R6: A new input edge on an active pulse-mode source makes it both active and pending. The return then leaves it pending and not active.
- R7: A `clr_pend` bit on a level-mode source has no effect while its input is high. Otherwise it clears the pending flag.
- R8: A `clr_pend` bit on a pulse-mode source clears the pending flag and leaves the active flag as it was.
- R9: A disabled source still becomes pending but is never offered. Setting its enable bit offers it without any further request.
- R10: The offered source is the enabled pending source with the numerically lowest priority value (the group compared first, then the sub-priority). Among equal values, the lowest source number wins.
- R11: While a handler runs, `take_req` is raised only if the winner's group value is strictly lower than the group of the top stack entry. When the handler returns, a waiting source is offered without an idle return to thread mode.
- R12: The group of a source is its priority value shifted right by `sub_bits`, so raising `sub_bits` can merge two priorities into one group that does not preempt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | NSRC | Raw request lines, one per source |
| src_en | input | NSRC | Per-source enable |
| pulse_mode | input | NSRC | 1 = pulse mode, 0 = level mode |
| prio_flat | input | NSRC*PRIO_W | Priority of source i at bits [i*PRIO_W +: PRIO_W] |
| sub_bits | input | $clog2(PRIO_W+1) | Number of low priority bits forming the sub-priority |
| set_pend | input | NSRC | One-cycle set-pending strobes |
| clr_pend | input | NSRC | One-cycle clear-pending strobes |
| entry | input | 1 | Core begins the handler of `take_id` |
| ret | input | 1 | Core returns from the current handler |
| take_req | output | 1 | A source should be taken now |
| take_id | output | $clog2(NSRC) | Number of the offered source |
| pending | output | NSRC | Pending flag per source |
| active | output | NSRC | Active flag per source |

## Verification
A wrong pending or active flag appears on `pending`/`active` on the clock edge after the stimulus that caused it. The error also spreads into `take_req`/`take_id` in the same cycle, because arbitration is combinational from those flags. A corrupted nesting stack stays hidden until a return. After the return, the wrong execution priority shows up as a missed or spurious preemption, or a missed tail-chain offer. Because of this, the bench checks the offer after every return as well as after every request.

// File: rtl/nvt_pkg.sv
package nvt_pkg;
    typedef enum logic {
        S_THREAD  = 1'b0,
        S_HANDLER = 1'b1
    } nvt_state_e;
endpackage

// File: rtl/nvt_src.sv
module nvt_src (
    input  logic clk,
    input  logic rst_n,
    input  logic irq,
    input  logic pulse_mode,
    input  logic set_i,
    input  logic clr_i,
    input  logic ent_i,
    input  logic ret_i,
    output logic pend,
    output logic act
);
    logic irq_q;
    logic edge_hit;
    logic pend_nx;
    logic act_nx;

    assign edge_hit = irq & ~irq_q;

    always_comb begin
        if (ent_i) begin
            pend_nx = 1'b0;
        end else if (pulse_mode) begin
            pend_nx = clr_i ? 1'b0 : (pend | set_i | edge_hit);
        end else if (clr_i && !irq) begin
            pend_nx = 1'b0;
        end else begin
            pend_nx = pend | set_i | (irq & (~act | ret_i));
        end
        act_nx = ent_i | (act & ~ret_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
            pend  <= 1'b0;
            act   <= 1'b0;
        end else begin
            irq_q <= irq;
            pend  <= pend_nx;
            act   <= act_nx;
        end
    end
endmodule

// File: rtl/nvt_arb.sv
module nvt_arb #(
    parameter int NSRC   = 8,
    parameter int PRIO_W = 3,
    localparam int IDW   = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic [NSRC-1:0]        cand,
    input  logic [NSRC*PRIO_W-1:0] prio_flat,
    output logic                   found,
    output logic [IDW-1:0]         win_id,
    output logic [PRIO_W-1:0]      win_prio
);
    always_comb begin
        found    = 1'b0;
        win_id   = '0;
        win_prio = '1;
        for (int k = 0; k < NSRC; k++) begin
            if (cand[k] && (!found || prio_flat[k*PRIO_W +: PRIO_W] < win_prio)) begin
                found    = 1'b1;
                win_id   = IDW'(k);
                win_prio = prio_flat[k*PRIO_W +: PRIO_W];
            end
        end
    end
endmodule

// File: rtl/nvt_stack.sv
module nvt_stack #(
    parameter int NSRC = 8,
    localparam int IDW = (NSRC > 1) ? $clog2(NSRC) : 1,
    localparam int DW  = $clog2(NSRC + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           push,
    input  logic [IDW-1:0] push_id,
    input  logic           pop,
    output logic [IDW-1:0] top_id,
    output logic           nonempty,
    output logic           single
);
    logic [IDW-1:0] stk [NSRC];
    logic [DW-1:0]  depth;

    assign nonempty = (depth != '0);
    assign single   = (depth == DW'(1));

    always_comb begin
        top_id = '0;
        for (int k = 0; k < NSRC; k++) begin
            if (depth == DW'(k + 1)) top_id = stk[k];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            depth <= '0;
            for (int k = 0; k < NSRC; k++) stk[k] <= '0;
        end else if (push && depth < DW'(NSRC)) begin
            for (int k = 0; k < NSRC; k++) begin
                if (depth == DW'(k)) stk[k] <= push_id;
            end
            depth <= depth + DW'(1);
        end else if (pop && nonempty) begin
            depth <= depth - DW'(1);
        end
    end
endmodule

// File: rtl/nvt_top.sv
module nvt_top
    import nvt_pkg::*;
#(
    parameter int NSRC   = 8,
    parameter int PRIO_W = 3,
    localparam int IDW   = (NSRC > 1) ? $clog2(NSRC) : 1,
    localparam int SBW   = $clog2(PRIO_W + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NSRC-1:0]        irq_in,
    input  logic [NSRC-1:0]        src_en,
    input  logic [NSRC-1:0]        pulse_mode,
    input  logic [NSRC*PRIO_W-1:0] prio_flat,
    input  logic [SBW-1:0]         sub_bits,
    input  logic [NSRC-1:0]        set_pend,
    input  logic [NSRC-1:0]        clr_pend,
    input  logic                   entry,
    input  logic                   ret,
    output logic                   take_req,
    output logic [IDW-1:0]         take_id,
    output logic [NSRC-1:0]        pending,
    output logic [NSRC-1:0]        active
);
    nvt_state_e        state, state_nx;
    logic              found;
    logic [PRIO_W-1:0] win_prio;
    logic [PRIO_W-1:0] cur_prio;
    logic [PRIO_W-1:0] win_grp;
    logic [PRIO_W-1:0] cur_grp;
    logic [IDW-1:0]    top_id;
    logic              nonempty;
    logic              single;
    logic              ent_ok;
    logic              ret_ok;

    assign ent_ok = entry && take_req;
    assign ret_ok = ret && nonempty;

    nvt_arb #(.NSRC(NSRC), .PRIO_W(PRIO_W)) u_arb (
        .cand      (pending & src_en),
        .prio_flat (prio_flat),
        .found     (found),
        .win_id    (take_id),
        .win_prio  (win_prio)
    );

    nvt_stack #(.NSRC(NSRC)) u_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (ent_ok),
        .push_id  (take_id),
        .pop      (ret_ok),
        .top_id   (top_id),
        .nonempty (nonempty),
        .single   (single)
    );

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        nvt_src u_src (
            .clk        (clk),
            .rst_n      (rst_n),
            .irq        (irq_in[i]),
            .pulse_mode (pulse_mode[i]),
            .set_i      (set_pend[i]),
            .clr_i      (clr_pend[i]),
            .ent_i      (ent_ok && take_id == IDW'(i)),
            .ret_i      (ret_ok && top_id == IDW'(i)),
            .pend       (pending[i]),
            .act        (active[i])
        );
    end

    always_comb begin
        cur_prio = '0;
        for (int k = 0; k < NSRC; k++) begin
            if (top_id == IDW'(k)) cur_prio = prio_flat[k*PRIO_W +: PRIO_W];
        end
        win_grp = win_prio >> sub_bits;
        cur_grp = cur_prio >> sub_bits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_THREAD;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_THREAD:  if (ent_ok)           state_nx = S_HANDLER;
            S_HANDLER: if (ret_ok && single) state_nx = S_THREAD;
            default:                         state_nx = S_THREAD;
        endcase
    end

    always_comb begin
        unique case (state)
            S_THREAD:  take_req = found;
            S_HANDLER: take_req = found && (win_grp < cur_grp);
            default:   take_req = 1'b0;
        endcase
    end
endmodule

// File: rtl/nvt_chk.sv
module nvt_chk #(
    parameter int NSRC = 8,
    localparam int IDW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NSRC-1:0] src_en,
    input logic            entry,
    input logic            ret,
    input logic            take_req,
    input logic [IDW-1:0]  take_id,
    input logic [NSRC-1:0] pending,
    input logic [NSRC-1:0] active
);
    // R9
    offer_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_req |-> (src_en[take_id] && pending[take_id]));

    // R4
    entry_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (entry && take_req) |=> active[$past(take_id)]);

    // R11
    thread_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active == '0 && (pending & src_en) != '0) |-> take_req);

    // R5
    return_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret && !entry && active != '0) |=> ($countones(active) + 1 == $countones($past(active))));
endmodule

bind nvt_top nvt_chk #(.NSRC(NSRC)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_en   (src_en),
    .entry    (entry),
    .ret      (ret),
    .take_req (take_req),
    .take_id  (take_id),
    .pending  (pending),
    .active   (active)
);

// File: tb/nvt_top_bench.sv
module nvt_top_bench;
    localparam int NSRC = 8;
    localparam int PW   = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] irq_in = '0, src_en = '1, pulse_mode = 8'hF0;
    logic [NSRC*PW-1:0] prio_flat = '1;
    logic [1:0]      sub_bits = '0;
    logic [NSRC-1:0] set_pend = '0, clr_pend = '0;
    logic            entry = 1'b0, ret = 1'b0;
    logic            take_req;
    logic [2:0]      take_id;
    logic [NSRC-1:0] pending, active;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        string      tag;
        logic [7:0] p;
        logic [7:0] a;
        logic       t;
        logic [2:0] id;
    } exp_t;
    exp_t expq[$];

    always #10 clk = ~clk;

    nvt_top #(.NSRC(NSRC), .PRIO_W(PW)) u_nvt_top (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .src_en(src_en),
        .pulse_mode(pulse_mode), .prio_flat(prio_flat), .sub_bits(sub_bits),
        .set_pend(set_pend), .clr_pend(clr_pend), .entry(entry), .ret(ret),
        .take_req(take_req), .take_id(take_id), .pending(pending), .active(active)
    );

    task automatic expect_st(input string tag, input logic [7:0] p, input logic [7:0] a,
                             input logic t, input logic [2:0] id);
        exp_t e;
        e.tag = tag; e.p = p; e.a = a; e.t = t; e.id = id;
        expq.push_back(e);
    endtask

    task automatic clk1();
        @(posedge clk);
        #1;
    endtask

    task automatic at_neg();
        @(negedge clk);
    endtask

    task automatic set_prio(input int i, input logic [PW-1:0] v);
        prio_flat[i*PW +: PW] = v;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            #5;
            while (expq.size() > 0) begin
                exp_t e;
                e = expq.pop_front();
                checks++;
                if (pending !== e.p || active !== e.a || take_req !== e.t ||
                    (e.t && take_id !== e.id)) begin
                    errors++;
                    $display("FAIL %s: pend=%h act=%h take=%b id=%0d expected pend=%h act=%h take=%b id=%0d",
                             e.tag, pending, active, take_req, take_id, e.p, e.a, e.t, e.id);
                end
            end
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        at_neg(); at_neg();
        rst_n = 1'b1;
        clk1(); expect_st("R1 reset", 8'h00, 8'h00, 1'b0, 3'd0);

        // level source 1
        at_neg(); irq_in[1] = 1'b1;
        clk1(); expect_st("R2 level pend", 8'h02, 8'h00, 1'b1, 3'd1);
        at_neg(); entry = 1'b1;
        clk1(); expect_st("R4 entry", 8'h00, 8'h02, 1'b0, 3'd0);
        at_neg(); entry = 1'b0;
        clk1(); expect_st("R2 high while active", 8'h00, 8'h02, 1'b0, 3'd0);
        at_neg(); ret = 1'b1;
        clk1(); expect_st("R5 return input high", 8'h02, 8'h00, 1'b1, 3'd1);
        at_neg(); ret = 1'b0; entry = 1'b1;
        clk1(); expect_st("R4 re-entry", 8'h00, 8'h02, 1'b0, 3'd0);
        at_neg(); entry = 1'b0; irq_in[1] = 1'b0; ret = 1'b1;
        clk1(); expect_st("R5 return input low", 8'h00, 8'h00, 1'b0, 3'd0);
        at_neg(); ret = 1'b0;

        // level clear
        irq_in[2] = 1'b1;
        clk1(); expect_st("R2 level pend src2", 8'h04, 8'h00, 1'b1, 3'd2);
        at_neg(); clr_pend = 8'h04;
        clk1(); expect_st("R7 clear ignored while high", 8'h04, 8'h00, 1'b1, 3'd2);
        at_neg(); clr_pend = 8'h00; irq_in[2] = 1'b0;
        clk1(); expect_st("R7 pend held after drop", 8'h04, 8'h00, 1'b1, 3'd2);
        at_neg(); clr_pend = 8'h04;
        clk1(); expect_st("R7 clear when low", 8'h00, 8'h00, 1'b0, 3'd0);
        at_neg(); clr_pend = 8'h00;

        // pulse source 4
        irq_in[4] = 1'b1;
        clk1(); expect_st("R3 edge pend", 8'h10, 8'h00, 1'b1, 3'd4);
        at_neg(); clr_pend = 8'h10;
        clk1(); expect_st("R3 held high no re-pend", 8'h00, 8'h00, 1'b0, 3'd0);
        at_neg(); clr_pend = 8'h00; irq_in[4] = 1'b0;

        // pulse source 5 via set-pending
        set_pend = 8'h20;
        clk1(); expect_st("R3 set-pending", 8'h20, 8'h00, 1'b1, 3'd5);
        at_neg(); set_pend = 8'h00; entry = 1'b1;
        clk1(); expect_st("R4 pulse entry", 8'h00, 8'h20, 1'b0, 3'd0);
        at_neg(); entry = 1'b0; irq_in[5] = 1'b1;
        clk1(); expect_st("R6 edge while active", 8'h20, 8'h20, 1'b0, 3'd0);
        at_neg(); irq_in[5] = 1'b0; clr_pend = 8'h20;
        clk1(); expect_st("R8 clear keeps active", 8'h00, 8'h20, 1'b0, 3'd0);
        at_neg(); clr_pend = 8'h00; irq_in[5] = 1'b1;
        clk1(); expect_st("R6 second edge", 8'h20, 8'h20, 1'b0, 3'd0);
        at_neg(); irq_in[5] = 1'b0; ret = 1'b1;
        clk1(); expect_st("R6 return leaves pending", 8'h20, 8'h00, 1'b1, 3'd5);
        at_neg(); ret = 1'b0; clr_pend = 8'h20;
        clk1(); expect_st("R8 clear pending only", 8'h00, 8'h00, 1'b0, 3'd0);
        at_neg(); clr_pend = 8'h00;

        // disabled source 3
        src_en = 8'hF7; irq_in[3] = 1'b1;
        clk1(); expect_st("R9 pend while disabled", 8'h08, 8'h00, 1'b0, 3'd0);
        at_neg(); src_en = 8'hFF;
        clk1(); expect_st("R9 offered on enable", 8'h08, 8'h00, 1'b1, 3'd3);
        at_neg(); irq_in[3] = 1'b0; clr_pend = 8'h08;
        clk1(); expect_st("R7 clear src3", 8'h00, 8'h00, 1'b0, 3'd0);
        at_neg(); clr_pend = 8'h00;

        // arbitration
        set_prio(4, 3'd5); set_prio(6, 3'd2); set_prio(7, 3'd2);
        set_pend = 8'hF0;
        clk1(); expect_st("R10 tie lower index", 8'hF0, 8'h00, 1'b1, 3'd6);
        at_neg(); set_pend = 8'h00; clr_pend = 8'h40;
        clk1(); expect_st("R10 next lowest", 8'hB0, 8'h00, 1'b1, 3'd7);
        at_neg(); clr_pend = 8'h00; entry = 1'b1;
        clk1(); expect_st("R11 no preempt lower urgency", 8'h30, 8'h80, 1'b0, 3'd0);
        at_neg(); entry = 1'b0; set_prio(4, 3'd1);
        clk1(); expect_st("R11 preempt strictly lower", 8'h30, 8'h80, 1'b1, 3'd4);
        at_neg(); entry = 1'b1;
        clk1(); expect_st("R11 nested entry", 8'h20, 8'h90, 1'b0, 3'd0);
        at_neg(); entry = 1'b0; ret = 1'b1;
        clk1(); expect_st("R11 pop to outer", 8'h20, 8'h80, 1'b0, 3'd0);
        at_neg();
        clk1(); expect_st("R11 tail-chain offer", 8'h20, 8'h00, 1'b1, 3'd5);
        at_neg(); ret = 1'b0; clr_pend = 8'h20;
        clk1(); expect_st("R8 clear src5", 8'h00, 8'h00, 1'b0, 3'd0);
        at_neg(); clr_pend = 8'h00;

        // grouping
        set_prio(7, 3'd3); set_prio(0, 3'd1); set_pend = 8'h40;
        clk1(); expect_st("R10 single pend", 8'h40, 8'h00, 1'b1, 3'd6);
        at_neg(); set_pend = 8'h00; entry = 1'b1;
        clk1(); expect_st("R4 entry src6", 8'h00, 8'h40, 1'b0, 3'd0);
        at_neg(); entry = 1'b0; sub_bits = 2'd2; set_pend = 8'h01;
        clk1(); expect_st("R12 same group no preempt", 8'h01, 8'h40, 1'b0, 3'd0);
        at_neg(); set_pend = 8'h00; sub_bits = 2'd0;
        clk1(); expect_st("R12 split groups preempt", 8'h01, 8'h40, 1'b1, 3'd0);

        at_neg(); at_neg();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule